// File: doc/BRIEF.md
# Deferred Snoop Invalidation Queue

This block sits beside one private cache and takes invalidation requests that other agents put on the coherence bus. An invalidation that arrives while there is room in the queue is acknowledged in the same cycle and stored. It reaches the cache's invalidate port later. Until then the cache keeps serving the old copy of that line. Stored entries go to the cache in arrival order whenever the cache's invalidate port is ready. The core never looks into the queue.

Ordering is kept by two means. First, an outgoing coherence message that the cache wants to send is held while any queued entry names the same address. Second, a load-load fence request raises a busy output, and that output stays high until the queue is empty. When the queue is full, a new invalidation skips the queue. It is driven straight onto the cache port and is acknowledged only in the cycle the cache accepts it.

Top module: `snoop_inv_queue`

## Requirements
- R1: After synchronous reset the queue holds nothing: `inv_valid`, `snoop_ack`, `msg_hold` and `fence_busy` are all low.
- R2: While fewer than DEPTH entries are queued, a raised `snoop_valid` is acknowledged in that same cycle and its address is queued. The cache port does not need to accept it first.
- R3: When the queue is not bypassed, `inv_valid` is high exactly when at least one entry is queued. `inv_addr` shows the oldest entry. An entry leaves the queue in a cycle where `inv_valid` and `inv_ready` are both high.
- R4: While DEPTH entries are queued, a raised `snoop_valid` takes the cache port ahead of the queue (`inv_valid` high, `inv_addr` equal to `snoop_addr`). It is acknowledged only in a cycle where `inv_ready` is high, and it is never queued.
- R5: `msg_hold` is high exactly when `msg_valid` is high and `msg_addr` equals the address of some queued entry.
- R6: `fence_busy` is high in any cycle where `fence_req` is high, or a fence is pending, and the queue is not empty. A fence stays pending until the queue becomes empty. A fence raised on an empty queue gives no busy cycle.
- R7: The queue never holds more than DEPTH entries. A further invalidation while full and while `inv_ready` is low is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snoop_valid | input | 1 | Invalidate request from the bus; held until acknowledged |
| snoop_addr | input | ADDR_W | Line address of the invalidate request |
| snoop_ack | output | 1 | Acknowledge for the current invalidate request |
| inv_valid | output | 1 | Invalidate command to the cache |
| inv_addr | output | ADDR_W | Line address to invalidate in the cache |
| inv_ready | input | 1 | Cache accepts the invalidate command this cycle |
| msg_valid | input | 1 | Cache wants to send a coherence message |
| msg_addr | input | ADDR_W | Line address of that outgoing message |
| msg_hold | output | 1 | Outgoing message must wait: a matching invalidation is still queued |
| fence_req | input | 1 | Load-load fence issued by the core |
| fence_busy | output | 1 | Core must stall its following loads |

## Verification
The assertions assume that the bus keeps `snoop_valid` high and `snoop_addr` unchanged from the first cycle of a request until the cycle it is acknowledged. The stimulus honours this. A new request is started only after the previous one has been acknowledged, and its address is frozen until then. The addresses come from a set of eight values, so message matches, duplicate lines and a full queue all occur often. The cache's ready rate is changed between phases so that the queue spends long stretches both full and empty.

// File: rtl/siq_pkg.sv
package siq_pkg;

    // Source currently driving the cache invalidate port
    typedef enum logic [1:0] {
        PORT_IDLE   = 2'd0,
        PORT_QUEUE  = 2'd1,
        PORT_DIRECT = 2'd2
    } port_src_e;

    // Occupancy update step
    typedef enum logic [1:0] {
        OCC_HOLD = 2'd0,
        OCC_INC  = 2'd1,
        OCC_DEC  = 2'd2
    } occ_step_e;

    function automatic occ_step_e occ_step(input logic push, input logic pop);
        occ_step_e s;
        case ({push, pop})
            2'b10:   s = OCC_INC;
            2'b01:   s = OCC_DEC;
            default: s = OCC_HOLD;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/siq_store.sv
module siq_store
    import siq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           push,
    input  logic [ADDR_W-1:0]              push_addr,
    input  logic                           pop,
    output logic [ADDR_W-1:0]              head_addr,
    output logic [CNT_W-1:0]               occ,
    output logic [CNT_W-1:0]               occ_nxt,
    output logic                           full,
    output logic                           empty,
    output logic [DEPTH-1:0]               slot_vld,
    output logic [DEPTH-1:0][ADDR_W-1:0]   slot_addr
);

    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [DEPTH-1:0][ADDR_W-1:0] mem_q;
    logic [DEPTH-1:0]             vld_q, vld_d;
    logic [PTR_W-1:0]             rd_q, wr_q;
    logic [CNT_W-1:0]             occ_q;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        case (occ_step(push, pop))
            OCC_INC: occ_nxt = occ_q + CNT_W'(1);
            OCC_DEC: occ_nxt = occ_q - CNT_W'(1);
            default: occ_nxt = occ_q;
        endcase
    end

    always_comb begin
        vld_d = vld_q;
        if (pop)  vld_d[rd_q] = 1'b0;
        if (push) vld_d[wr_q] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            wr_q  <= '0;
            occ_q <= '0;
            vld_q <= '0;
        end else begin
            if (push) wr_q <= ptr_inc(wr_q);
            if (pop)  rd_q <= ptr_inc(rd_q);
            occ_q <= occ_nxt;
            vld_q <= vld_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[wr_q] <= push_addr;
    end

    assign head_addr = mem_q[rd_q];
    assign occ       = occ_q;
    assign full      = (occ_q == FULL_CNT);
    assign empty     = (occ_q == '0);
    assign slot_vld  = vld_q;
    assign slot_addr = mem_q;

endmodule

// File: rtl/siq_match.sv
module siq_match #(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic [DEPTH-1:0]             slot_vld,
    input  logic [DEPTH-1:0][ADDR_W-1:0] slot_addr,
    input  logic                         msg_valid,
    input  logic [ADDR_W-1:0]            msg_addr,
    output logic                         hit
);

    logic [DEPTH-1:0] slot_hit;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign slot_hit[i] = slot_vld[i] && (slot_addr[i] == msg_addr);
    end

    assign hit = msg_valid && (|slot_hit);

endmodule

// File: rtl/siq_fence.sv
module siq_fence #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fence_req,
    input  logic [CNT_W-1:0] occ,
    input  logic [CNT_W-1:0] occ_nxt,
    output logic             busy
);

    logic pend_q;
    logic armed;

    assign armed = fence_req || pend_q;
    assign busy  = armed && (occ != '0);

    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= armed && (occ_nxt != '0);
    end

endmodule

// File: rtl/snoop_inv_queue.sv
module snoop_inv_queue
    import siq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              snoop_ack,
    output logic              inv_valid,
    output logic [ADDR_W-1:0] inv_addr,
    input  logic              inv_ready,
    input  logic              msg_valid,
    input  logic [ADDR_W-1:0] msg_addr,
    output logic              msg_hold,
    input  logic              fence_req,
    output logic              fence_busy
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic                         push, pop, full, empty;
    logic [ADDR_W-1:0]            head_addr;
    logic [CNT_W-1:0]             occ, occ_nxt;
    logic [DEPTH-1:0]             slot_vld;
    logic [DEPTH-1:0][ADDR_W-1:0] slot_addr;
    port_src_e                    src;

    // Port source: a full queue lets the new request go straight through
    always_comb begin
        if (snoop_valid && full) src = PORT_DIRECT;
        else if (!empty)         src = PORT_QUEUE;
        else                     src = PORT_IDLE;
    end

    always_comb begin
        case (src)
            PORT_DIRECT: inv_addr = snoop_addr;
            PORT_QUEUE:  inv_addr = head_addr;
            default:     inv_addr = '0;
        endcase
    end

    assign inv_valid = (src != PORT_IDLE);
    assign pop       = (src == PORT_QUEUE) && inv_ready;
    assign push      = snoop_valid && !full;
    assign snoop_ack = push || ((src == PORT_DIRECT) && inv_ready);

    siq_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_addr (snoop_addr),
        .pop       (pop),
        .head_addr (head_addr),
        .occ       (occ),
        .occ_nxt   (occ_nxt),
        .full      (full),
        .empty     (empty),
        .slot_vld  (slot_vld),
        .slot_addr (slot_addr)
    );

    siq_match #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_match (
        .slot_vld  (slot_vld),
        .slot_addr (slot_addr),
        .msg_valid (msg_valid),
        .msg_addr  (msg_addr),
        .hit       (msg_hold)
    );

    siq_fence #(.CNT_W(CNT_W)) u_fence (
        .clk       (clk),
        .rst       (rst),
        .fence_req (fence_req),
        .occ       (occ),
        .occ_nxt   (occ_nxt),
        .busy      (fence_busy)
    );

endmodule

// File: rtl/siq_checker.sv
module siq_checker #(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 4,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              snoop_valid,
    input logic [ADDR_W-1:0] snoop_addr,
    input logic              snoop_ack,
    input logic              inv_valid,
    input logic [ADDR_W-1:0] inv_addr,
    input logic              inv_ready,
    input logic              msg_valid,
    input logic              msg_hold,
    input logic              fence_busy,
    input logic [CNT_W-1:0]  occ
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    p_clear_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (occ == '0) && !fence_busy && !msg_hold);

    p_ack_when_room_r2: assert property (@(posedge clk) disable iff (rst)
        (snoop_valid && occ < FULL_CNT) |-> snoop_ack);

    p_port_busy_when_queued_r3: assert property (@(posedge clk) disable iff (rst)
        (occ != '0) |-> inv_valid);

    p_direct_on_port_r4: assert property (@(posedge clk) disable iff (rst)
        (snoop_valid && occ == FULL_CNT) |-> inv_valid && (inv_addr == snoop_addr));

    p_direct_waits_r4: assert property (@(posedge clk) disable iff (rst)
        (snoop_valid && occ == FULL_CNT && !inv_ready) |-> !snoop_ack);

    p_hold_needs_entry_r5: assert property (@(posedge clk) disable iff (rst)
        msg_hold |-> msg_valid && (occ != '0));

    p_idle_no_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (occ == '0) |-> !fence_busy);

    p_busy_persists_r6: assert property (@(posedge clk) disable iff (rst)
        (fence_busy && !inv_ready && !snoop_valid) |=> fence_busy);

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        occ <= FULL_CNT);

endmodule

bind snoop_inv_queue siq_checker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .snoop_valid (snoop_valid),
    .snoop_addr  (snoop_addr),
    .snoop_ack   (snoop_ack),
    .inv_valid   (inv_valid),
    .inv_addr    (inv_addr),
    .inv_ready   (inv_ready),
    .msg_valid   (msg_valid),
    .msg_hold    (msg_hold),
    .fence_busy  (fence_busy),
    .occ         (occ)
);

// File: tb/snoop_inv_queue_bench.sv
module snoop_inv_queue_bench;

    localparam int CLK_P = 10;
    localparam int AW    = 16;
    localparam int DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          snoop_valid = 1'b0;
    logic [AW-1:0] snoop_addr  = '0;
    logic          inv_ready   = 1'b0;
    logic          msg_valid   = 1'b0;
    logic [AW-1:0] msg_addr    = '0;
    logic          fence_req   = 1'b0;
    logic          snoop_ack, inv_valid, msg_hold, fence_busy;
    logic [AW-1:0] inv_addr;

    int compared   = 0;
    int mismatched = 0;
    bit done       = 0;

    logic [AW-1:0] mq[$];
    bit            mpend = 0;
    bit            last_ack = 0;

    always #(CLK_P/2) clk = ~clk;

    snoop_inv_queue #(.ADDR_W(AW), .DEPTH(DEPTH)) u_snoop_inv_queue (
        .clk(clk), .rst(rst),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .snoop_ack(snoop_ack),
        .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_ready(inv_ready),
        .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_hold(msg_hold),
        .fence_req(fence_req), .fence_busy(fence_busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Compare one cycle against the reference model, then advance the model
    task automatic step();
        bit full, direct, e_cv, e_ack, e_hold, e_busy, hit, pop, push;
        logic [AW-1:0] e_ca;
        #2;
        full   = (mq.size() == DEPTH);
        direct = snoop_valid && full;
        e_cv   = direct || (mq.size() != 0);
        e_ca   = direct ? snoop_addr : ((mq.size() != 0) ? mq[0] : '0);
        e_ack  = snoop_valid && (!full || inv_ready);
        hit    = 0;
        foreach (mq[i]) if (mq[i] == msg_addr) hit = 1;
        e_hold = msg_valid && hit;
        e_busy = (fence_req || mpend) && (mq.size() != 0);
        chk(full ? "R4 R7 snoop_ack while full" : "R2 snoop_ack with room",
            32'(snoop_ack), 32'(e_ack));
        chk(direct ? "R4 inv_valid direct" : "R3 inv_valid", 32'(inv_valid), 32'(e_cv));
        if (e_cv) chk(direct ? "R4 inv_addr direct" : "R3 inv_addr oldest",
                      32'(inv_addr), 32'(e_ca));
        chk("R5 msg_hold", 32'(msg_hold), 32'(e_hold));
        chk("R6 fence_busy", 32'(fence_busy), 32'(e_busy));
        last_ack = e_ack;
        @(posedge clk);
        pop  = !direct && (mq.size() != 0) && inv_ready;
        push = snoop_valid && !full;
        if (pop)  void'(mq.pop_front());
        if (push) mq.push_back(snoop_addr);
        mpend = (fence_req || mpend) && (mq.size() != 0);
    endtask

    task automatic drive(input bit sv, input logic [AW-1:0] sa, input bit rdy,
                         input bit mv, input logic [AW-1:0] ma, input bit fr);
        @(negedge clk);
        snoop_valid = sv; snoop_addr = sa; inv_ready = rdy;
        msg_valid = mv; msg_addr = ma; fence_req = fr;
        step();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        msg_valid = 1'b1;
        msg_addr  = 16'h0005;
        #2;
        chk("R1 inv_valid after reset", 32'(inv_valid), 32'd0);
        chk("R1 snoop_ack after reset", 32'(snoop_ack), 32'd0);
        chk("R1 msg_hold after reset", 32'(msg_hold), 32'd0);
        chk("R1 fence_busy after reset", 32'(fence_busy), 32'd0);
        @(posedge clk);

        // R2: fill the queue while the cache port is stalled
        for (int i = 0; i < DEPTH; i++) drive(1, AW'(16'h10 + i), 0, 0, '0, 0);
        // R5: a match and a miss
        drive(0, '0, 0, 1, 16'h0012, 0);
        drive(0, '0, 0, 1, 16'h0044, 0);
        // R4, R7: full queue, direct request waits for the cache
        drive(1, 16'h0020, 0, 0, '0, 0);
        drive(1, 16'h0020, 0, 1, 16'h0020, 0);
        drive(1, 16'h0020, 1, 0, '0, 0);
        // R6: fence while stalled, then drain
        drive(0, '0, 0, 0, '0, 1);
        drive(0, '0, 0, 0, '0, 0);
        drive(0, '0, 0, 0, '0, 0);
        for (int i = 0; i < DEPTH + 2; i++) drive(0, '0, 1, 1, 16'h0013, 0);
        // R6: fence on an empty queue
        drive(0, '0, 1, 0, '0, 1);
        // R3: push and pop in the same cycle
        drive(1, 16'h0031, 1, 0, '0, 0);
        drive(1, 16'h0032, 1, 0, '0, 0);
        drive(0, '0, 1, 0, '0, 0);

        begin
            bit sv = 0;
            logic [AW-1:0] sa = '0;
            for (int n = 0; n < 6000; n++) begin
                bit rdy;
                if (!sv && $urandom_range(0, 2) != 0) begin
                    sv = 1;
                    sa = AW'($urandom_range(0, 7));
                end
                if (n < 3000) rdy = ($urandom_range(0, 3) == 0);
                else          rdy = ($urandom_range(0, 3) != 0);
                drive(sv, sa, rdy, $urandom_range(0, 1) == 1,
                      AW'($urandom_range(0, 7)), $urandom_range(0, 15) == 0);
                if (last_ack) sv = 0;
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule